// File: doc/BRIEF.md
# Region-Based Memory Access Checker

This block sits in front of a memory bus and judges every access against a small table of eight programmable protection regions. Each region has a base address, a power-of-two size, eight subregion-disable bits and two permission fields, one for privileged and one for unprivileged accesses. The verdict is combinational, in the same cycle as the access. When an access is refused, the first such fault is captured in a register set that holds the faulting address and its direction until software clears it.

Software fills the table through a single-cycle register write port. A global enable bit turns the whole check on. While that bit is clear, every access passes. Where enabled regions overlap, the region with the highest number decides the verdict. A disabled subregion takes no part in matching, so a lower-numbered region beneath it can decide instead.

Top module: `region_guard`

## Requirements
- R1: After reset the global enable is clear, every region is disabled and no fault is latched (flt_valid = 0).
- R2: While the global enable is clear, every access is allowed (acc_allow = acc_valid, acc_fault = 0).
- R3: With the global enable set, an access that matches no enabled region is refused (acc_fault = 1, acc_allow = 0).
- R4: A region of size field s covers 2^s bytes starting at its base with the low s bits cleared. s is clamped to the range 8 to 32, and s = 32 covers the whole address space.
- R5: A region splits into eight equal subregions indexed by address bits [s-1:s-3]. When bit k of the region's subregion-disable mask is set, subregion k does not match.
- R6: When several enabled regions match an address, the highest-numbered one decides the verdict.
- R7: The permission field is selected by acc_priv (privileged when 1). The code 00 refuses every access, 01 allows reads only (acc_write = 0), and 10 or 11 allows reads and writes.
- R8: One cycle after a refused access, if no fault was already latched, flt_valid becomes 1 and flt_addr and flt_write take that access's address and write flag. A later fault does not change them while flt_valid is 1.
- R9: flt_clr clears flt_valid on the next edge and takes precedence over a fault arriving in the same cycle, which is then not recorded.
- R10: A write with cfg_we = 1 takes effect on the next edge. cfg_addr = {0,0,i} writes the base of region i. cfg_addr = {0,1,i} writes the attributes of region i: bit 0 enable, bits [6:1] size exponent, bits [15:8] subregion-disable mask, bits [17:16] privileged permission, bits [19:18] unprivileged permission. cfg_addr[4] = 1 writes the global enable from bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration register select |
| cfg_wdata | input | AW | Configuration write data |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | AW | Access address |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| acc_priv | input | 1 | 1 for a privileged access |
| acc_allow | output | 1 | Access permitted |
| acc_fault | output | 1 | Access refused |
| flt_clr | input | 1 | Clear the latched fault |
| flt_valid | output | 1 | A fault is latched |
| flt_addr | output | AW | Address of the latched fault |
| flt_write | output | 1 | Write flag of the latched fault |

## Verification
The embedded assertions check the fault-capture register on every cycle. They confirm that the first fault is captured with its address, that a latched fault holds while no clear arrives, that a clear empties the register, and that nothing is refused while the global enable is off. Only the bench scenarios can show region matching and its effects: size clamping, the masking of base bits, subregion holes that expose a lower region, overlap priority, and the permission codes for each privilege level. The bench checks these against a model that decides membership by arithmetic range comparison rather than by bit masks.

// File: rtl/region_guard.sv
module region_guard #(
  parameter int AW   = 32,
  parameter int NREG = 8,
  localparam int IW  = $clog2(NREG),
  localparam int SW  = $clog2(AW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [4:0]    cfg_addr,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          acc_valid,
  input  logic [AW-1:0] acc_addr,
  input  logic          acc_write,
  input  logic          acc_priv,
  output logic          acc_allow,
  output logic          acc_fault,
  input  logic          flt_clr,
  output logic          flt_valid,
  output logic [AW-1:0] flt_addr,
  output logic          flt_write
);

  logic [AW-1:0] r_base [NREG];
  logic          r_en   [NREG];
  logic [SW-1:0] r_sz   [NREG];
  logic [7:0]    r_srd  [NREG];
  logic [1:0]    r_pp   [NREG];
  logic [1:0]    r_up   [NREG];
  logic          gen_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_en <= 1'b0;
      for (int i = 0; i < NREG; i++) begin
        r_base[i] <= '0;
        r_en[i]   <= 1'b0;
        r_sz[i]   <= '0;
        r_srd[i]  <= '0;
        r_pp[i]   <= '0;
        r_up[i]   <= '0;
      end
    end else if (cfg_we) begin
      if (cfg_addr[4]) gen_en <= cfg_wdata[0];
      else if (!cfg_addr[3]) r_base[cfg_addr[IW-1:0]] <= cfg_wdata;
      else begin
        r_en[cfg_addr[IW-1:0]]  <= cfg_wdata[0];
        r_sz[cfg_addr[IW-1:0]]  <= cfg_wdata[SW:1];
        r_srd[cfg_addr[IW-1:0]] <= cfg_wdata[15:8];
        r_pp[cfg_addr[IW-1:0]]  <= cfg_wdata[17:16];
        r_up[cfg_addr[IW-1:0]]  <= cfg_wdata[19:18];
      end
    end
  end

  logic          hit;
  logic [1:0]    perm;
  logic [SW-1:0] sz;
  logic [AW-1:0] mask;
  logic [2:0]    sub;

  always_comb begin
    hit  = 1'b0;
    perm = 2'b00;
    sz   = '0;
    mask = '0;
    sub  = '0;
    for (int i = 0; i < NREG; i++) begin
      sz   = (r_sz[i] < SW'(8)) ? SW'(8) : ((r_sz[i] > SW'(AW)) ? SW'(AW) : r_sz[i]);
      mask = {AW{1'b1}} << sz;
      sub  = 3'(acc_addr >> (sz - SW'(3)));
      if (r_en[i] && (((acc_addr ^ r_base[i]) & mask) == '0) && !r_srd[i][sub]) begin
        hit  = 1'b1;
        perm = acc_priv ? r_pp[i] : r_up[i];
      end
    end
  end

  wire ok = !gen_en || (hit && (perm[1] || (perm[0] && !acc_write)));
  assign acc_allow = acc_valid && ok;
  assign acc_fault = acc_valid && !ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt_valid <= 1'b0;
      flt_addr  <= '0;
      flt_write <= 1'b0;
    end else if (flt_clr) begin
      flt_valid <= 1'b0;
    end else if (acc_fault && !flt_valid) begin
      flt_valid <= 1'b1;
      flt_addr  <= acc_addr;
      flt_write <= acc_write;
    end
  end

  // R8
  flt_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fault && !flt_valid && !flt_clr |=> flt_valid && flt_addr == $past(acc_addr) && flt_write == $past(acc_write));

  // R8
  flt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid && !flt_clr |=> flt_valid && $stable(flt_addr) && $stable(flt_write));

  // R9
  flt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flt_clr |=> !flt_valid);

  // R2
  off_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !gen_en |-> acc_allow && !acc_fault);

endmodule

// File: tb/sim_region_guard.sv
module sim_region_guard;
  localparam int CLK_NS = 10;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [4:0] cfg_addr = 0;
  logic [31:0] cfg_wdata = 0;
  logic acc_valid = 0, acc_write = 0, acc_priv = 0, flt_clr = 0;
  logic [31:0] acc_addr = 0;
  logic acc_allow, acc_fault, flt_valid, flt_write;
  logic [31:0] flt_addr;

  always #(CLK_NS/2) clk = ~clk;

  region_guard u0 (.clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .acc_valid, .acc_addr,
    .acc_write, .acc_priv, .acc_allow, .acc_fault, .flt_clr, .flt_valid, .flt_addr, .flt_write);

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [31:0] m_base [8];
  bit          m_en   [8];
  int          m_sz   [8];
  logic [7:0]  m_srd  [8];
  logic [1:0]  m_pp   [8];
  logic [1:0]  m_up   [8];
  bit          m_gen;
  bit          mv, mw;
  logic [31:0] ma;

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit m_allow(logic [31:0] a, bit w, bit p);
    bit hit;
    logic [1:0] pm;
    int s;
    logic [63:0] span, lo, a64;
    int sub;
    hit = 0; pm = 0; a64 = {32'b0, a};
    if (!m_gen) return 1;
    for (int i = 0; i < 8; i++) begin
      s = m_sz[i] < 8 ? 8 : (m_sz[i] > 32 ? 32 : m_sz[i]);
      span = 64'd1 << s;
      lo = ({32'b0, m_base[i]} / span) * span;
      if (m_en[i] && a64 >= lo && a64 < lo + span) begin
        sub = int'((a64 - lo) / (span / 8));
        if (!m_srd[i][sub]) begin
          hit = 1;
          pm = p ? m_pp[i] : m_up[i];
        end
      end
    end
    if (!hit) return 0;
    if (pm == 2'b00) return 0;
    if (pm == 2'b01) return !w;
    return 1;
  endfunction

  // R10 configuration writes
  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    acc_valid = 0; flt_clr = 0;
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    if (a[4]) m_gen = d[0];
    else if (!a[3]) m_base[a[2:0]] = d;
    else begin
      m_en[a[2:0]] = d[0]; m_sz[a[2:0]] = int'(d[6:1]);
      m_srd[a[2:0]] = d[15:8]; m_pp[a[2:0]] = d[17:16]; m_up[a[2:0]] = d[19:18];
    end
  endtask

  task automatic region(int i, logic [31:0] b, bit en, int s, logic [7:0] srd, logic [1:0] pp, logic [1:0] up);
    wr({2'b00, 3'(i)}, b);
    wr({2'b01, 3'(i)}, {12'b0, up, pp, srd, 1'b0, 6'(s), en});
  endtask

  task automatic step(bit v, logic [31:0] a, bit w, bit p, bit clr, string req);
    bit e;
    @(negedge clk);
    cfg_we = 0;
    chk(flt_valid == mv, "R8/R9 flt_valid", flt_valid, mv);
    if (mv) begin
      chk(flt_addr == ma, "R8 flt_addr", flt_addr, ma);
      chk(flt_write == mw, "R8 flt_write", flt_write, mw);
    end
    acc_valid = v; acc_addr = a; acc_write = w; acc_priv = p; flt_clr = clr;
    #1;
    e = m_allow(a, w, p);
    chk(acc_allow == (v && e), req, acc_allow, v && e);
    chk(acc_fault == (v && !e), req, acc_fault, v && !e);
    if (clr) mv = 0;
    else if (v && !e && !mv) begin mv = 1; ma = a; mw = w; end
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      m_base[i] = 0; m_en[i] = 0; m_sz[i] = 0; m_srd[i] = 0; m_pp[i] = 0; m_up[i] = 0;
    end
    m_gen = 0; mv = 0; mw = 0; ma = 0;
    void'($urandom(32'h5EED_1234));
    #(CLK_NS * 3);
    rst_n = 1;

    // R1 reset state, R2 disabled check passes everything
    step(0, 0, 0, 0, 0, "R1 idle");
    chk(flt_valid == 0, "R1 flt_valid after reset", flt_valid, 0);
    step(1, 32'hDEAD_BEEF, 1, 0, 0, "R1 R2 write while disabled");
    step(1, 32'h0000_0010, 0, 1, 0, "R2 read while disabled");

    // R3 enabled, no regions
    wr(5'h10, 1);
    step(1, 32'h0000_4000, 1, 1, 0, "R3 no region write");
    step(1, 32'h0000_5000, 0, 0, 0, "R3 second fault ignored by latch");
    step(1, 32'h0000_6000, 0, 1, 1, "R9 clear with fault");
    step(0, 0, 0, 0, 0, "R9 idle");
    step(1, 32'h0000_7000, 0, 1, 0, "R8 fault after clear");
    step(0, 0, 0, 0, 1, "R9 clear");

    // R4 base and size
    region(1, 32'h0000_1000, 1, 12, 8'h00, 2'b11, 2'b11);
    step(1, 32'h0000_1FFF, 1, 0, 0, "R4 top of region");
    step(1, 32'h0000_2000, 0, 0, 1, "R4 just past region");
    step(1, 32'h0000_0FFF, 0, 0, 1, "R4 just below region");
    wr(5'h01, 32'h0000_1234);
    step(1, 32'h0000_1000, 1, 1, 1, "R4 unaligned base masked");
    region(2, 32'h0000_8000, 1, 3, 8'h00, 2'b11, 2'b11);
    step(1, 32'h0000_80FF, 0, 1, 1, "R4 size clamped to 256");
    step(1, 32'h0000_8100, 0, 1, 1, "R4 clamped region end");

    // R5 subregions
    region(1, 32'h0000_1000, 1, 12, 8'h04, 2'b11, 2'b11);
    step(1, 32'h0000_1400, 0, 1, 1, "R5 disabled subregion");
    step(1, 32'h0000_1200, 0, 1, 1, "R5 enabled subregion");
    region(0, 32'h0000_0000, 1, 32, 8'h00, 2'b01, 2'b01);
    step(1, 32'h0000_1400, 0, 0, 1, "R5 R4 hole exposes whole-space read only");
    step(1, 32'h0000_1400, 1, 0, 1, "R5 R7 hole write refused");
    step(1, 32'hF000_0000, 0, 1, 1, "R4 size 32 covers top");

    // R6 priority
    region(5, 32'h0000_1000, 1, 8, 8'h00, 2'b00, 2'b00);
    step(1, 32'h0000_1010, 0, 1, 1, "R6 higher region no access wins");
    step(1, 32'h0000_1110, 1, 1, 1, "R6 outside higher region");
    region(5, 32'h0000_1000, 0, 8, 8'h00, 2'b00, 2'b00);

    // R7 permission codes per privilege
    region(3, 32'h0010_0000, 1, 16, 8'h00, 2'b10, 2'b01);
    step(1, 32'h0010_0040, 1, 1, 1, "R7 privileged write rw");
    step(1, 32'h0010_0040, 1, 0, 1, "R7 unprivileged write ro");
    step(1, 32'h0010_0040, 0, 0, 1, "R7 unprivileged read ro");
    region(3, 32'h0010_0000, 1, 16, 8'h00, 2'b00, 2'b11);
    step(1, 32'h0010_0040, 0, 1, 1, "R7 privileged none");
    step(1, 32'h0010_0040, 1, 0, 0, "R7 unprivileged rw");
    step(1, 32'h0010_0044, 0, 1, 0, "R8 capture privileged read fault");
    step(1, 32'h0020_0000, 1, 1, 0, "R8 later fault ignored");
    step(0, 0, 0, 0, 1, "R9 clear");

    // random rounds
    for (int r = 0; r < 8; r++) begin
      for (int i = 0; i < 8; i++) begin
        int s;
        logic [31:0] b;
        s = ($urandom % 8 == 0) ? 32 : 6 + int'($urandom % 15);
        b = $urandom & 32'h000F_FFFF;
        region(i, b, ($urandom % 4) != 0, s, 8'($urandom) & 8'($urandom), 2'($urandom), 2'($urandom));
      end
      wr(5'h10, ($urandom % 6) != 0);
      for (int k = 0; k < 60; k++) begin
        logic [31:0] a;
        a = ($urandom % 10 == 0) ? $urandom : ($urandom & 32'h000F_FFFF);
        step($urandom % 5 != 0, a, 1'($urandom), 1'($urandom), ($urandom % 9) == 0, "R4/R5/R6/R7 random");
      end
    end
    step(0, 0, 0, 0, 0, "R8 final");
    step(0, 0, 0, 0, 0, "R8 final");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule